// File: doc/BRIEF.md
# Virtual Channel Input Port Buffer

This block is the receiving half of one router input port. Flits come in over a single physical link. Each flit carries a virtual channel index and a two-bit kind field. The block steers every flit into the flit queue of its virtual channel. It holds one independent FIFO per channel. For each channel it also tracks whether a packet is currently open, so that flits that break the head/body/tail order are caught.

Each channel presents its oldest flit on its own valid/ready pair. A stalled consumer on one channel never holds back another channel, so traffic on one channel can pass a packet that is blocked on a different channel. Every dequeue sends a one-cycle release pulse, one bit per channel. The upstream sender counts these pulses as credits.

Back-pressure rules: the input side has no ready signal. The sender may only send a flit to a channel for which it holds a credit, and a credit covers one flit slot, not a whole packet. A flit sent to a full channel, or one that breaks the packet order, is discarded and raises a sticky error. On the output side, a flit leaves channel v in any cycle where `deq_valid[v]` and `deq_ready[v]` are both high. `deq_ready` may be high while `deq_valid` is low, and this has no effect.

Top module: `vc_input_buffer`

## Requirements
- R1: After a synchronous reset, all `deq_valid` bits, all `release_pulse` bits and `proto_err` are low, every queue is empty and every channel is idle (no packet open).
- R2: An accepted flit goes only into the queue selected by the binary `enq_vc` field. It shows on that channel's `deq_valid`/`deq_kind`/`deq_data` in the cycle after the edge that accepts it. The other channels are unchanged.
- R3: Each queue holds `DEPTH` flits and returns them in arrival order. Fullness is judged before any dequeue in the same cycle. A flit sent to a full queue is dropped, the stored flits are left intact and `proto_err` is set.
- R4: Kind encoding is 2'b00 head, 2'b01 body, 2'b10 tail and 2'b11 single-flit packet. A head or single flit is accepted only on an idle channel. A head leaves the channel active (packet open).
- R5: A body or tail flit is accepted only on an active channel. A tail or single flit leaves the channel idle.
- R6: A flit that breaks R4/R5, or that names a channel index of `NUM_VC` or above, is dropped. It sets `proto_err`, which stays high until reset whatever traffic follows.
- R7: A channel whose `deq_ready` is low does not stop dequeues on any other channel. Several channels may dequeue in the same cycle.
- R8: A dequeue on channel v drives `release_pulse[v]` high for exactly the one cycle after the dequeue edge. Simultaneous dequeues raise several bits. `deq_ready[v]` with `deq_valid[v]` low raises no pulse.
- R9: Buffering is granted one flit at a time. A packet longer than `DEPTH` flits passes through a channel when it is drained while the packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | A flit is present on the link this cycle |
| enq_vc | input | VC_W | Target virtual channel index |
| enq_kind | input | 2 | Flit kind (00 head, 01 body, 10 tail, 11 single) |
| enq_data | input | DATA_W | Flit payload |
| deq_valid | output | NUM_VC | Channel v has a flit at its queue head |
| deq_ready | input | NUM_VC | Consumer takes the head flit of channel v |
| deq_kind | output | 2*NUM_VC | Kind of each channel's head flit, channel v in bits [2v+1:2v] |
| deq_data | output | DATA_W*NUM_VC | Payload of each channel's head flit, channel v in slice v |
| release_pulse | output | NUM_VC | One-cycle pulse per dequeued slot, bit v for channel v |
| proto_err | output | 1 | Sticky flag: a flit was dropped for overflow, bad order or bad index |

## Verification
A wrong packet state for a channel shows up at the first flit to that channel afterwards. A legal flit is dropped and `proto_err` rises one edge later, or an illegal one is accepted and appears on `deq_valid`. A pointer or count error shows up when the queue is drained, as a payload out of order, a missing flit or an extra flit, or as a full queue that still accepts. Routing or release errors are visible in the cycle right after the edge concerned, because every output is at most one register away from the edge that causes it.

// File: rtl/vcib_pkg.sv
package vcib_pkg;

  typedef enum logic [1:0] {
    FK_HEAD = 2'b00,
    FK_BODY = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [1:0] k);
    return (k == FK_HEAD) || (k == FK_SOLO);
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return (k == FK_TAIL) || (k == FK_SOLO);
  endfunction

endpackage

// File: rtl/vcib_fifo.sv
module vcib_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] head_word,
  output logic             not_empty,
  output logic             is_full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head_word = slots[rd_ptr];
  assign not_empty = (fill != '0);
  assign is_full   = (fill == CW'(DEPTH));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  a_r3_push_has_room: assert property (@(posedge clk) disable iff (rst)
    push |-> !is_full);
  a_r2_pop_has_data: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty);
endmodule

// File: rtl/vcib_pkt_tracker.sv
module vcib_pkt_tracker
  import vcib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic [1:0] kind,
  input  logic       full,
  output logic       accept,
  output logic       violation
);
  logic active;
  logic order_ok;

  always_comb begin
    order_ok  = active ? !kind_opens(kind) : kind_opens(kind);
    accept    = sel && !full && order_ok;
    violation = sel && (full || !order_ok);
  end

  always_ff @(posedge clk) begin
    if (rst)
      active <= 1'b0;
    else if (accept)
      active <= !kind_closes(kind);
  end

  a_r4_head_opens: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == FK_HEAD) |=> active);
  a_r5_close_idles: assert property (@(posedge clk) disable iff (rst)
    (accept && kind_closes(kind)) |=> !active);
  a_r5_no_open_on_active: assert property (@(posedge clk) disable iff (rst)
    (accept && active) |-> !kind_opens(kind));
endmodule

// File: rtl/vcib_release.sv
module vcib_release #(
  parameter int NUM_VC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_VC-1:0] popped,
  output logic [NUM_VC-1:0] pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= '0;
    else     pulse <= popped;
  end
endmodule

// File: rtl/vc_input_buffer.sv
module vc_input_buffer
  import vcib_pkg::*;
#(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 3,
  parameter int DATA_W = 32,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enq_valid,
  input  logic [VC_W-1:0]          enq_vc,
  input  logic [1:0]               enq_kind,
  input  logic [DATA_W-1:0]        enq_data,
  output logic [NUM_VC-1:0]        deq_valid,
  input  logic [NUM_VC-1:0]        deq_ready,
  output logic [2*NUM_VC-1:0]      deq_kind,
  output logic [DATA_W*NUM_VC-1:0] deq_data,
  output logic [NUM_VC-1:0]        release_pulse,
  output logic                     proto_err
);
  localparam int WORD_W = DATA_W + 2;

  logic [NUM_VC-1:0] hit, acc, bad, full, pop;
  logic              idx_bad;

  assign idx_bad = enq_valid && (int'(enq_vc) >= NUM_VC);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [WORD_W-1:0] head_w;

    assign hit[v] = enq_valid && (int'(enq_vc) == v);
    assign pop[v] = deq_valid[v] && deq_ready[v];

    vcib_pkt_tracker u_trk (
      .clk       (clk),
      .rst       (rst),
      .sel       (hit[v]),
      .kind      (enq_kind),
      .full      (full[v]),
      .accept    (acc[v]),
      .violation (bad[v])
    );

    vcib_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .push      (acc[v]),
      .push_word ({enq_kind, enq_data}),
      .pop       (pop[v]),
      .head_word (head_w),
      .not_empty (deq_valid[v]),
      .is_full   (full[v])
    );

    assign deq_kind[2*v +: 2]       = head_w[WORD_W-1 -: 2];
    assign deq_data[DATA_W*v +: DATA_W] = head_w[DATA_W-1:0];

    a_r8_release_follows_pop: assert property (@(posedge clk) disable iff (rst)
      pop[v] |=> release_pulse[v]);
    a_r8_no_release_when_empty: assert property (@(posedge clk) disable iff (rst)
      !deq_valid[v] |=> !release_pulse[v]);
  end

  vcib_release #(.NUM_VC(NUM_VC)) u_rel (
    .clk    (clk),
    .rst    (rst),
    .popped (pop),
    .pulse  (release_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)
      proto_err <= 1'b0;
    else if (idx_bad || (|bad))
      proto_err <= 1'b1;
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc));
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !(|acc)) |=> proto_err);
endmodule

// File: tb/sim_vc_input_buffer.sv
`timescale 1ns/1ps
module sim_vc_input_buffer;
  localparam int NV = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          enq_valid;
  logic [0:0]    enq_vc;
  logic [1:0]    enq_kind;
  logic [DW-1:0] enq_data;
  logic [NV-1:0] deq_valid, deq_ready, release_pulse;
  logic [2*NV-1:0]  deq_kind;
  logic [DW*NV-1:0] deq_data;
  logic          proto_err;

  int n_chk = 0;
  int n_err = 0;

  vc_input_buffer #(.NUM_VC(NV), .DEPTH(3), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_vc(enq_vc),
    .enq_kind(enq_kind), .enq_data(enq_data), .deq_valid(deq_valid),
    .deq_ready(deq_ready), .deq_kind(deq_kind), .deq_data(deq_data),
    .release_pulse(release_pulse), .proto_err(proto_err)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; enq_valid = 1'b0; enq_vc = '0; enq_kind = '0; enq_data = '0;
    deq_ready = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input int vc, input logic [1:0] k, input logic [DW-1:0] d);
    enq_valid = 1'b1; enq_vc = vc[0:0]; enq_kind = k; enq_data = d;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic take(input int vc, input logic [1:0] k, input logic [DW-1:0] d, input string req);
    check({req, " valid"}, 64'(deq_valid[vc]), 64'd1);
    check({req, " data"}, 64'(deq_data[DW*vc +: DW]), 64'(d));
    check({req, " kind"}, 64'(deq_kind[2*vc +: 2]), 64'(k));
    deq_ready[vc] = 1'b1;
    @(negedge clk);
    deq_ready[vc] = 1'b0;
    check("R8 release bit", 64'(release_pulse[vc]), 64'd1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 deq_valid", 64'(deq_valid), 64'd0);
    check("R1 release", 64'(release_pulse), 64'd0);
    check("R1 proto_err", 64'(proto_err), 64'd0);
    send(0, 2'b01, 32'h5);
    check("R1 idle after reset (body rejected)", 64'(proto_err), 64'd1);
    check("R1 dropped body", 64'(deq_valid), 64'd0);
  endtask

  task automatic t_route();
    do_reset();
    send(1, 2'b00, 32'hA1);
    check("R2 only vc1 valid", 64'(deq_valid), 64'b10);
    take(1, 2'b00, 32'hA1, "R2 vc1 head");
    send(0, 2'b11, 32'hB0);
    check("R2 only vc0 valid", 64'(deq_valid), 64'b01);
    take(0, 2'b11, 32'hB0, "R2 vc0 single");
    check("R2 no error", 64'(proto_err), 64'd0);
  endtask

  task automatic t_overflow();
    do_reset();
    send(0, 2'b00, 32'hC0);
    send(0, 2'b01, 32'hC1);
    send(0, 2'b01, 32'hC2);
    check("R3 three stored, no error", 64'(proto_err), 64'd0);
    send(0, 2'b01, 32'hC3);
    check("R3 overflow error", 64'(proto_err), 64'd1);
    take(0, 2'b00, 32'hC0, "R3 order 1");
    take(0, 2'b01, 32'hC1, "R3 order 2");
    take(0, 2'b01, 32'hC2, "R3 order 3");
    check("R3 overflow flit dropped", 64'(deq_valid[0]), 64'd0);
  endtask

  task automatic t_order();
    do_reset();
    send(0, 2'b00, 32'h1);
    send(0, 2'b00, 32'h2);
    check("R4 head on active rejected", 64'(proto_err), 64'd1);
    send(1, 2'b11, 32'h3);
    send(1, 2'b00, 32'h4);
    check("R6 err sticky under legal traffic", 64'(proto_err), 64'd1);
    do_reset();
    send(1, 2'b11, 32'h10);
    send(1, 2'b10, 32'h11);
    check("R5 tail after single rejected", 64'(proto_err), 64'd1);
    take(1, 2'b11, 32'h10, "R6 single kept, tail dropped");
    check("R6 tail dropped", 64'(deq_valid[1]), 64'd0);
    do_reset();
    send(0, 2'b00, 32'h20);
    send(0, 2'b10, 32'h21);
    send(0, 2'b00, 32'h22);
    check("R5 tail returns idle", 64'(proto_err), 64'd0);
  endtask

  task automatic t_independent();
    do_reset();
    send(0, 2'b00, 32'h30);
    send(1, 2'b00, 32'h40);
    send(1, 2'b01, 32'h41);
    take(1, 2'b00, 32'h40, "R7 vc1 passes blocked vc0");
    check("R8 only vc1 released", 64'(release_pulse), 64'b10);
    check("R7 vc0 still held", 64'(deq_data[0 +: DW]), 64'h30);
    deq_ready = 2'b11;
    @(negedge clk);
    deq_ready = 2'b00;
    check("R8 two releases", 64'(release_pulse), 64'b11);
    check("R7 both drained", 64'(deq_valid), 64'd0);
    @(negedge clk);
    check("R8 pulse one cycle", 64'(release_pulse), 64'd0);
    deq_ready = 2'b11;
    @(negedge clk);
    @(negedge clk);
    deq_ready = 2'b00;
    check("R8 ready on empty no pulse", 64'(release_pulse), 64'd0);
  endtask

  task automatic t_long();
    do_reset();
    send(1, 2'b00, 32'h50);
    send(1, 2'b01, 32'h51);
    send(1, 2'b01, 32'h52);
    take(1, 2'b00, 32'h50, "R9 drain 1");
    send(1, 2'b01, 32'h53);
    take(1, 2'b01, 32'h51, "R9 drain 2");
    send(1, 2'b10, 32'h54);
    check("R9 five-flit packet accepted", 64'(proto_err), 64'd0);
    take(1, 2'b01, 32'h52, "R9 drain 3");
    take(1, 2'b01, 32'h53, "R9 drain 4");
    take(1, 2'b10, 32'h54, "R9 drain 5");
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_route();
    t_overflow();
    t_order();
    t_independent();
    t_long();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule